// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This controller sits between a synchronous host and a 128K x 8 asynchronous static RAM. The host issues single-beat read or write requests. The controller turns each request into a sequence of chip-enable, output-enable and write-enable levels on the RAM pins, and holds each phase for a whole number of clock cycles. Those counts are derived at elaboration from the RAM's nanosecond minimums and the clock period, always rounding up.

The RAM is selected only when its active-low enable is low and its active-high enable is high. Reads hold the output enable low for the access window and capture the returned byte on the last cycle of that window. Writes are always terminated by the write enable. The chip enables rise one cycle before the write-enable pulse and stay asserted for one cycle after it. The controller leaves the data bus undriven until the RAM's outputs have had time to float after the write enable falls. It drives the bus through the hold cycle. Every accepted request ends with a one-cycle done pulse.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset the RAM is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `done`=0 and `ready`=1.
- R2: A request is taken only on a clock edge where `ready` is 1. `req_valid` while busy has no effect on the pins, the address or the memory contents.
- R3: A read selects the RAM with `mem_we_n`=1 and `mem_oe_n`=0 for RD cycles, where RD is the largest of the rounded-up read-cycle, address-access and output-enable times (at least 1). `rdata` takes `mem_dq_i` from the last of those cycles and keeps it until the next read completes.
- R4: A write first spends one cycle selected with `mem_we_n`=1. It then drives `mem_we_n` low, then spends one cycle selected with `mem_we_n`=1, and only then deselects.
- R5: The write-enable low time is WP cycles. WP is the largest of four values: the rounded-up pulse width, the rounded-up float time plus the rounded-up data setup (setup at least 1), the rounded-up address setup minus 1, and the rounded-up write-cycle time minus 2.
- R6: `mem_dq_oe` is 1 only in the last WP minus FZ cycles of the write-enable pulse and in the following hold cycle, where FZ is the rounded-up float time. `mem_dq_o` then equals the write data.
- R7: Each accepted request gives exactly one single-cycle `done` pulse on the cycle after the pins return to idle. `ready` is 1 on the next cycle.
- R8: `mem_oe_n`=0 and `mem_we_n`=0 each occur only while the RAM is selected, and never together.
- R9: `mem_addr` stays at the accepted address for the whole time the RAM is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Idle, request may be issued |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 17 | RAM address pins |
| mem_ce1_n | output | 1 | RAM enable, active low |
| mem_ce2 | output | 1 | RAM enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Byte toward the RAM data pins |
| mem_dq_oe | output | 1 | Enable of the pad driver for `mem_dq_o` |
| mem_dq_i | input | 8 | Byte from the RAM data pins |

## Verification
The assertions assume that `mem_dq_i` is a settled value whenever the read window closes. They also assume that the host never needs a request taken while `ready` is low. The stimulus respects both. The bench's RAM model answers only while selected with output enable low, and it stores a byte only while write enable is low and the pad driver is on. Each request is raised for one edge while `ready` is 1. Requests issued while busy are deliberate, and they are withdrawn before the controller returns to idle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_WR_SETUP = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4,
    ST_FINISH   = 3'd5
  } seq_state_t;

  // ceiling of ns / clk_ns, zero for non-positive times
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    if (ns <= 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int at_least_one(input int a);
    return (a < 1) ? 1 : a;
  endfunction

  function automatic int read_cycles(input int t_rc, input int t_aa,
                                     input int t_oe, input int clk_ns);
    int c;
    c = max_of(ns_to_cycles(t_rc, clk_ns), ns_to_cycles(t_aa, clk_ns));
    c = max_of(c, ns_to_cycles(t_oe, clk_ns));
    return at_least_one(c);
  endfunction

  function automatic int float_cycles(input int t_wz, input int clk_ns);
    return ns_to_cycles(t_wz, clk_ns);
  endfunction

  // write-enable low time: pulse width, float gap plus data setup,
  // address setup (one setup cycle precedes), write cycle (setup + hold)
  function automatic int pulse_cycles(input int t_pwe, input int t_wz,
                                      input int t_ds, input int t_aw,
                                      input int t_wc, input int clk_ns);
    int c;
    c = ns_to_cycles(t_pwe, clk_ns);
    c = max_of(c, ns_to_cycles(t_wz, clk_ns) + at_least_one(ns_to_cycles(t_ds, clk_ns)));
    c = max_of(c, ns_to_cycles(t_aw, clk_ns) - 1);
    c = max_of(c, ns_to_cycles(t_wc, clk_ns) - 2);
    return at_least_one(c);
  endfunction

  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign expired = (count == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 2,
  parameter int FZ_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic ready,
  output logic accept,
  output logic capture,
  output logic finish,
  output logic sel_act,
  output logic oe_act,
  output logic we_act,
  output logic drv_act
);

  localparam int MAXC = max_of(RD_CYC, WP_CYC);
  localparam int CW   = count_width(MAXC);
  localparam logic [CW-1:0] RD_LOAD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LOAD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] DRV_FROM = CW'(WP_CYC - 1 - FZ_CYC);

  seq_state_t state, state_nx;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic [CW-1:0] tmr_cnt;
  logic          tmr_done;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_cnt),
    .expired  (tmr_done)
  );

  // named events
  assign ready   = (state == ST_IDLE);
  assign accept  = ready && req_valid;
  assign capture = (state == ST_RD_ACC) && tmr_done;
  assign finish  = (state == ST_FINISH);

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (req_write) begin
          state_nx = ST_WR_SETUP;
        end else begin
          state_nx = ST_RD_ACC;
          tmr_load = 1'b1;
          tmr_val  = RD_LOAD;
        end
      end
      ST_RD_ACC:   if (tmr_done) state_nx = ST_FINISH;
      ST_WR_SETUP: begin
        state_nx = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = WP_LOAD;
      end
      ST_WR_PULSE: if (tmr_done) state_nx = ST_WR_HOLD;
      ST_WR_HOLD:  state_nx = ST_FINISH;
      ST_FINISH:   state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign sel_act = (state == ST_RD_ACC) || (state == ST_WR_SETUP) ||
                   (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
  assign oe_act  = (state == ST_RD_ACC);
  assign we_act  = (state == ST_WR_PULSE);
  assign drv_act = ((state == ST_WR_PULSE) && (tmr_cnt <= DRV_FROM)) ||
                   (state == ST_WR_HOLD);

  // length of the current write-enable pulse, for the checks below
  logic [CW:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      we_run <= '0;
    else if (we_act) we_run <= we_run + 1'b1;
    else             we_run <= '0;
  end

  AST_CE_LEADS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_act) |-> $past(sel_act)); // R4
  AST_CE_OUTLASTS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_act) |-> sel_act); // R4
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_act) |-> (we_run == (CW+1)'(WP_CYC))); // R5
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    we_act |-> (we_run < (CW+1)'(WP_CYC))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish && ready); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready); // R2
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_act && we_act)); // R8
  AST_FINISH_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> $past(sel_act) && !sel_act); // R7

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          sel_act,
  input  logic          drv_act,
  input  logic          we_act,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  output logic [DW-1:0] rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_i;
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = drv_act;
  assign rdata     = rdata_q;

  AST_DRV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> we_act || $past(we_act)); // R6
  AST_DRV_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> sel_act); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act && $past(sel_act)) |-> $stable(mem_addr)); // R9
  AST_RDATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(rdata)); // R3

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 20,
  parameter int T_RC_NS  = 35,
  parameter int T_AA_NS  = 35,
  parameter int T_OE_NS  = 10,
  parameter int T_WC_NS  = 35,
  parameter int T_AW_NS  = 25,
  parameter int T_PWE_NS = 25,
  parameter int T_DS_NS  = 20,
  parameter int T_WZ_NS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_CYC = read_cycles(T_RC_NS, T_AA_NS, T_OE_NS, CLK_NS);
  localparam int FZ_CYC = float_cycles(T_WZ_NS, CLK_NS);
  localparam int WP_CYC = pulse_cycles(T_PWE_NS, T_WZ_NS, T_DS_NS, T_AW_NS, T_WC_NS, CLK_NS);

  logic accept, capture, finish;
  logic sel_act, oe_act, we_act, drv_act;

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .FZ_CYC (FZ_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .ready     (ready),
    .accept    (accept),
    .capture   (capture),
    .finish    (finish),
    .sel_act   (sel_act),
    .oe_act    (oe_act),
    .we_act    (we_act),
    .drv_act   (drv_act)
  );

  sram_data_path #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .sel_act   (sel_act),
    .drv_act   (drv_act),
    .we_act    (we_act),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rdata     (rdata)
  );

  assign mem_ce1_n = ~sel_act;
  assign mem_ce2   = sel_act;
  assign mem_oe_n  = ~oe_act;
  assign mem_we_n  = ~we_act;
  assign done      = finish;

  AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2)); // R8
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n)); // R8
  AST_ENABLES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce1_n == ~mem_ce2); // R8
  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(ready)); // R3

endmodule

// File: tb/test_sram_access_ctrl.sv
module test_sram_access_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, done;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int n_run = 0;
  int n_fail = 0;

  // expected counts, worked out from the requirements at 20 ns:
  // RD = max(ceil 35/20, ceil 35/20, ceil 10/20) = 2
  // FZ = ceil 10/20 = 1
  // WP = max(ceil 25/20, 1 + ceil 20/20, ceil 25/20 - 1, ceil 35/20 - 2) = 2
  localparam int EXP_RD = 2;
  localparam int EXP_WP = 2;
  localparam int EXP_FZ = 1;

  always #10 clk = ~clk;

  sram_access_ctrl i_sram_access_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rdata(rdata), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // RAM model
  logic [7:0] ram [0:4095];
  wire ram_sel = !mem_ce1_n && mem_ce2;
  always @(negedge clk)
    if (ram_sel && !mem_we_n && mem_dq_oe) ram[mem_addr[11:0]] <= mem_dq_o;
  assign mem_dq_i = (ram_sel && !mem_oe_n) ? ram[mem_addr[11:0]] : 8'h00;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // per-transfer observations
  int ob_oe_low, ob_we_low, ob_drv, ob_drv_early, ob_bad_drv_data, ob_done;
  int ob_setup_ok, ob_hold_ok, ob_addr_moves, ob_sel_cycles, ob_busy_ready;
  int ob_sel_bad;

  task automatic transfer(input bit wr, input logic [16:0] a, input logic [7:0] d,
                          input bit busy_poke);
    int  we_seen;
    bit  prev_sel, prev_we_low, done_seen;
    logic [16:0] first_addr;
    ob_oe_low = 0; ob_we_low = 0; ob_drv = 0; ob_drv_early = 0;
    ob_bad_drv_data = 0; ob_done = 0; ob_setup_ok = 0; ob_hold_ok = 0;
    ob_addr_moves = 0; ob_sel_cycles = 0; ob_busy_ready = 0; ob_sel_bad = 0;
    we_seen = 0; prev_sel = 0; prev_we_low = 0; done_seen = 0; first_addr = '0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (busy_poke) begin
      req_write = 1'b0; req_addr = a ^ 17'h00555; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    for (int i = 0; i < 40 && !done_seen; i++) begin
      if (ready) ob_busy_ready++;
      if (ram_sel) begin
        if (ob_sel_cycles == 0) first_addr = mem_addr;
        else if (mem_addr != first_addr) ob_addr_moves++;
        ob_sel_cycles++;
      end
      if (!mem_oe_n) begin
        ob_oe_low++;
        if (!ram_sel || !mem_we_n) ob_sel_bad++;
      end
      if (!mem_we_n) begin
        if (!ram_sel) ob_sel_bad++;
        if (we_seen == 0 && prev_sel) ob_setup_ok = 1;
        we_seen++;
        ob_we_low++;
      end
      if (mem_dq_oe) begin
        ob_drv++;
        if (!mem_we_n && we_seen <= EXP_FZ) ob_drv_early++;
        if (mem_we_n && !prev_we_low) ob_drv_early++;
        if (mem_dq_o != d) ob_bad_drv_data++;
      end
      if (prev_we_low && mem_we_n && ram_sel) ob_hold_ok = 1;
      if (done) begin
        done_seen = 1; ob_done++;
        req_valid = 1'b0;
        if (ram_sel) ob_sel_bad++;
      end
      prev_sel = ram_sel; prev_we_low = !mem_we_n;
      if (!done_seen) @(negedge clk);
    end
    @(negedge clk);
    if (done) ob_done++;
  endtask

  task automatic t_reset;
    check(mem_ce1_n === 1'b1 && mem_ce2 === 1'b0, "R1", "deselected after reset",
          {mem_ce1_n, mem_ce2}, 2'b10);
    check(mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R1", "we/oe idle after reset",
          {mem_we_n, mem_oe_n}, 2'b11);
    check(mem_dq_oe === 1'b0 && done === 1'b0 && ready === 1'b1, "R1",
          "driver off, done low, ready high", {mem_dq_oe, done, ready}, 3'b001);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    transfer(1'b1, a, d, 1'b0);
    check(ob_setup_ok == 1, "R4", "selected one cycle before we falls", ob_setup_ok, 1);
    check(ob_hold_ok == 1, "R4", "hold cycle selected after we rises", ob_hold_ok, 1);
    check(ob_sel_cycles == EXP_WP + 2, "R4", "selected cycles of a write",
          ob_sel_cycles, EXP_WP + 2);
    check(ob_we_low == EXP_WP, "R5", "we low cycles", ob_we_low, EXP_WP);
    check(ob_drv == EXP_WP - EXP_FZ + 1, "R6", "driver cycles", ob_drv, EXP_WP - EXP_FZ + 1);
    check(ob_drv_early == 0 && ob_bad_drv_data == 0, "R6", "driver window and data",
          ob_drv_early + ob_bad_drv_data, 0);
    check(ob_done == 1, "R7", "done pulses on write", ob_done, 1);
    check(ready === 1'b1, "R7", "ready after write", ready, 1);
    check(ob_sel_bad == 0 && ob_oe_low == 0, "R8", "we/oe only when legal",
          ob_sel_bad + ob_oe_low, 0);
    check(ob_addr_moves == 0 && mem_addr == a, "R9", "address held", mem_addr, a);
  endtask

  task automatic t_read(input logic [16:0] a, input logic [7:0] exp);
    transfer(1'b0, a, 8'h00, 1'b0);
    check(ob_oe_low == EXP_RD, "R3", "oe low cycles", ob_oe_low, EXP_RD);
    check(rdata == exp, "R3", "read data", rdata, exp);
    check(ob_we_low == 0 && ob_drv == 0, "R8", "no write activity on read",
          ob_we_low + ob_drv, 0);
    check(ob_done == 1 && ready === 1'b1, "R7", "done once then ready", ob_done, 1);
    check(ob_addr_moves == 0 && ob_sel_bad == 0, "R9", "address held on read",
          ob_addr_moves + ob_sel_bad, 0);
  endtask

  task automatic t_busy_ignore(input logic [16:0] a, input logic [7:0] d,
                               input logic [7:0] victim_old);
    transfer(1'b1, a, d, 1'b1);
    check(ob_oe_low == 0, "R2", "no read started by busy request", ob_oe_low, 0);
    check(ob_busy_ready == 0, "R2", "ready low while busy", ob_busy_ready, 0);
    check(ob_addr_moves == 0, "R2", "address unaffected by busy request", ob_addr_moves, 0);
    repeat (3) @(negedge clk);
    check(mem_ce1_n === 1'b1 && ready === 1'b1, "R2", "idle after ignored request",
          {mem_ce1_n, ready}, 2'b11);
    t_read(a ^ 17'h00555, victim_old);
    t_read(a, d);
  endtask

  task automatic t_rdata_hold(input logic [7:0] exp);
    t_write(17'h00042, 8'h3C);
    check(rdata == exp, "R3", "rdata kept across a write", rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write(17'h00000, 8'hA5);
    t_write(17'h1FFFF, 8'h5A);
    t_write(17'h00123, 8'hFF);
    t_write(17'h00123 ^ 17'h00555, 8'h0F);
    t_read(17'h00000, 8'hA5);
    t_read(17'h1FFFF, 8'h5A);
    t_read(17'h00123, 8'hFF);
    t_busy_ignore(17'h00123, 8'h81, 8'h0F);
    t_rdata_hold(8'h81);
    t_write(17'h00000, 8'h00);
    t_read(17'h00000, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule